// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the status and control word that sits beside a floating-point arithmetic unit. After each operation that reports exceptions, the arithmetic unit gives one strobe and five raw exception bits. The block replaces the per-operation flag field with those bits and folds them into a cause field. If any enabled cause is present, it raises a one-cycle trap request that carries a fixed vector code. The arithmetic unit itself lies outside this block.

The block also decodes two controls for the arithmetic unit. The first is a rounding-mode field, which selects truncation or round-to-nearest-even. The second is a single bit that makes denormal values flush to zero. Software writes the word through a masked write port and reads it back on a read port. Compare operations also go through the block: an ordered compare loads the condition bit, and an unordered compare updates the status fields and leaves the condition bit as it was.

Top module: `fpsc_ctrl`

## Requirements
- R1: After reset, rd_data, trap_req, trap_code, cond_bit, round_to_zero and flush_denorm are all zero.
- R2: A write with wr_en stores wr_data bits [17:0], and it is visible on rd_data from the next cycle. Bits [31:18] always read as zero. The field layout is: [1:0] rounding mode, [6:2] flags, [11:7] enables, [16:12] causes, [17] flush-to-zero.
- R3: round_to_zero is 1 exactly when the stored rounding-mode field equals 2'b01. Every other value gives 0, which means round-to-nearest-even.
- R4: flush_denorm follows the stored bit 17.
- R5: A status-updating strobe replaces the flag field with op_exc, so op_exc = 0 clears it. A status-updating strobe is op_done with op_is_cmp = 0, or op_done with op_is_cmp = 1 and cmp_unord = 1. Within every five-bit exception field, the bit order is: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid.
- R6: On a status-updating strobe with op_exc nonzero, the cause field becomes its previous value ORed with op_exc. With op_exc zero, the cause field is unchanged.
- R7: trap_req is high for the one cycle after a status-updating strobe when op_exc is nonzero and (new cause AND enable) is nonzero. In every other cycle it is low. trap_code reads 0x120 while trap_req is high and 0 otherwise.
- R8: An ordered compare (op_done, op_is_cmp = 1, cmp_unord = 0) loads cmp_true into cond_bit and leaves the whole status word unchanged. op_exc is ignored in this case.
- R9: An unordered compare updates the flags, the causes and the trap exactly as R5 to R7 describe, and it leaves cond_bit unchanged.
- R10: When a write and a status-updating strobe come in the same cycle, the mode, enable and flush fields are taken from the write. The flag field becomes op_exc. The cause field becomes the written cause ORed with op_exc, and the trap decision uses the written enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current status word, reserved bits zero |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Raw exception bits of the completing operation |
| op_is_cmp | input | 1 | The completing operation is a compare |
| cmp_unord | input | 1 | The compare result is unordered |
| cmp_true | input | 1 | The compare outcome for an ordered compare |
| cond_bit | output | 1 | Stored comparison result |
| round_to_zero | output | 1 | 1 selects truncation, 0 selects nearest-even |
| flush_denorm | output | 1 | Flush denormal values to zero |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Trap vector code while trap_req is high |

## Verification
Random cycles mix writes of arbitrary words, including reserved bits, with strobes whose exception bits may be zero or nonzero, and with compares of both kinds. This shows whether the flag field is replaced rather than accumulated, and whether the cause field accumulates only on nonzero exceptions. Directed cases cover the following:
- A trap caused by an enable that was set earlier, with a quiet cycle after it, which shows the trap is a pulse.
- A trap caused by an older cause bit when the new exception is not itself enabled.
- Ordered and unordered compares, which show which of the two updates the condition bit and which updates the status.
- A write in the same cycle as a strobe, which shows which source wins for each field.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
    localparam int NEXC      = 5;
    localparam int RM_W      = 2;
    localparam int REG_W     = 32;
    localparam int RM_LSB    = 0;
    localparam int FLAG_LSB  = RM_LSB + RM_W;
    localparam int EN_LSB    = FLAG_LSB + NEXC;
    localparam int CAUSE_LSB = EN_LSB + NEXC;
    localparam int FTZ_BIT   = CAUSE_LSB + NEXC;
    localparam int USED_W    = FTZ_BIT + 1;

    typedef struct packed {
        logic [RM_W-1:0] rm;
        logic [NEXC-1:0] flag;
        logic [NEXC-1:0] enable;
        logic [NEXC-1:0] cause;
        logic            ftz;
        logic            cond;
        logic            trap;
    } fpsc_state_t;
endpackage

// File: rtl/fpsc_mode_decode.sv
module fpsc_mode_decode #(
    parameter int              RM_W    = 2,
    parameter logic [RM_W-1:0] RM_ZERO = 2'b01
) (
    input  logic [RM_W-1:0] rm,
    input  logic            ftz,
    output logic            round_to_zero,
    output logic            flush_denorm
);
    // Only the one code truncates; every other code rounds to nearest even.
    assign round_to_zero = (rm == RM_ZERO);
    assign flush_denorm  = ftz;
endmodule

// File: rtl/fpsc_exc_merge.sv
module fpsc_exc_merge #(
    parameter int NEXC = 5
) (
    input  logic            upd,
    input  logic [NEXC-1:0] exc,
    input  logic [NEXC-1:0] cause_in,
    input  logic [NEXC-1:0] enable,
    output logic [NEXC-1:0] flag_out,
    output logic [NEXC-1:0] cause_out,
    output logic            trap
);
    logic            any_exc;
    logic [NEXC-1:0] hit;

    assign any_exc  = upd && (exc != '0);
    assign flag_out = exc;

    for (genvar i = 0; i < NEXC; i++) begin : g_bit
        assign cause_out[i] = cause_in[i] | (any_exc & exc[i]);
        assign hit[i]       = cause_out[i] & enable[i];
    end

    assign trap = any_exc && (hit != '0);
endmodule

// File: rtl/fpsc_ctrl.sv
module fpsc_ctrl
    import fpsc_pkg::*;
#(
    parameter logic [RM_W-1:0]  RM_ZERO_CODE = 2'b01,
    parameter int               VEC_W        = 12,
    parameter logic [VEC_W-1:0] TRAP_VEC     = 12'h120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             op_done,
    input  logic [NEXC-1:0]  op_exc,
    input  logic             op_is_cmp,
    input  logic             cmp_unord,
    input  logic             cmp_true,
    output logic             cond_bit,
    output logic             round_to_zero,
    output logic             flush_denorm,
    output logic             trap_req,
    output logic [VEC_W-1:0] trap_code
);
    fpsc_state_t st_q, st_d;

    logic [RM_W-1:0] base_rm;
    logic [NEXC-1:0] base_flag, base_en, base_cause;
    logic            base_ftz;
    logic            upd, ord_cmp;
    logic [NEXC-1:0] new_flag, new_cause;
    logic            new_trap;

    // Written value wins for every field; strobe effects are applied on top.
    always_comb begin
        base_rm    = st_q.rm;
        base_flag  = st_q.flag;
        base_en    = st_q.enable;
        base_cause = st_q.cause;
        base_ftz   = st_q.ftz;
        if (wr_en) begin
            base_rm    = wr_data[RM_LSB +: RM_W];
            base_flag  = wr_data[FLAG_LSB +: NEXC];
            base_en    = wr_data[EN_LSB +: NEXC];
            base_cause = wr_data[CAUSE_LSB +: NEXC];
            base_ftz   = wr_data[FTZ_BIT];
        end
    end

    assign upd     = op_done && (!op_is_cmp || cmp_unord);
    assign ord_cmp = op_done && op_is_cmp && !cmp_unord;

    fpsc_exc_merge #(.NEXC(NEXC)) u_merge (
        .upd      (upd),
        .exc      (op_exc),
        .cause_in (base_cause),
        .enable   (base_en),
        .flag_out (new_flag),
        .cause_out(new_cause),
        .trap     (new_trap)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rm     = base_rm;
        st_d.enable = base_en;
        st_d.ftz    = base_ftz;
        st_d.flag   = upd ? new_flag : base_flag;
        st_d.cause  = upd ? new_cause : base_cause;
        st_d.trap   = new_trap;
        if (ord_cmp) begin
            st_d.cond = cmp_true;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data                        = '0;
        rd_data[RM_LSB +: RM_W]        = st_q.rm;
        rd_data[FLAG_LSB +: NEXC]      = st_q.flag;
        rd_data[EN_LSB +: NEXC]        = st_q.enable;
        rd_data[CAUSE_LSB +: NEXC]     = st_q.cause;
        rd_data[FTZ_BIT]               = st_q.ftz;
    end

    fpsc_mode_decode #(.RM_W(RM_W), .RM_ZERO(RM_ZERO_CODE)) u_mode (
        .rm           (st_q.rm),
        .ftz          (st_q.ftz),
        .round_to_zero(round_to_zero),
        .flush_denorm (flush_denorm)
    );

    assign cond_bit  = st_q.cond;
    assign trap_req  = st_q.trap;
    assign trap_code = st_q.trap ? TRAP_VEC : '0;

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_is_cmp) |=> (rd_data[FLAG_LSB +: NEXC] == $past(op_exc))); // R5
    AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ((rd_data[CAUSE_LSB +: NEXC] & $past(op_exc)) == $past(op_exc))); // R6
    AST_TRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($past(upd) && ($past(op_exc) != '0))); // R7
    AST_TRAP_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_code == TRAP_VEC)); // R7
    AST_ORD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_cmp && !wr_en) |=> $stable(rd_data)); // R8
    AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_is_cmp && cmp_unord) |=> $stable(cond_bit)); // R9
endmodule

// File: tb/fpsc_ctrl_test.sv
module fpsc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        op_done;
    logic [4:0]  op_exc;
    logic        op_is_cmp, cmp_unord, cmp_true;
    logic        cond_bit, round_to_zero, flush_denorm, trap_req;
    logic [11:0] trap_code;

    int errors = 0;
    int checks = 0;

    // model state, built from the requirements
    logic [1:0] m_rm;
    logic [4:0] m_flag, m_en, m_cause;
    logic       m_ftz, m_cond, m_trap;

    always #10 clk = ~clk;

    fpsc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .op_done(op_done), .op_exc(op_exc), .op_is_cmp(op_is_cmp), .cmp_unord(cmp_unord),
        .cmp_true(cmp_true), .cond_bit(cond_bit), .round_to_zero(round_to_zero),
        .flush_denorm(flush_denorm), .trap_req(trap_req), .trap_code(trap_code)
    );

    function automatic logic [31:0] exp_word();
        return {14'd0, m_ftz, m_cause, m_en, m_flag, m_rm};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 R5 R6 R8 R9 R10 rd_data", rd_data, exp_word());
        chk("R3 round_to_zero", {31'd0, round_to_zero}, {31'd0, m_rm == 2'b01});
        chk("R4 flush_denorm", {31'd0, flush_denorm}, {31'd0, m_ftz});
        chk("R7 trap_req", {31'd0, trap_req}, {31'd0, m_trap});
        chk("R7 trap_code", {20'd0, trap_code}, m_trap ? 32'h120 : 32'h0);
        chk("R8 R9 cond_bit", {31'd0, cond_bit}, {31'd0, m_cond});
    endtask

    // one cycle: drive at negedge, update model, check at next negedge
    task automatic step(input logic w, input logic [31:0] wd, input logic od,
                        input logic [4:0] ex, input logic ic, input logic un, input logic ct);
        logic upd;
        wr_en = w; wr_data = wd; op_done = od; op_exc = ex;
        op_is_cmp = ic; cmp_unord = un; cmp_true = ct;
        @(posedge clk);
        if (w) begin
            m_rm = wd[1:0]; m_flag = wd[6:2]; m_en = wd[11:7];
            m_cause = wd[16:12]; m_ftz = wd[17];
        end
        upd = od && (!ic || un);
        m_trap = 1'b0;
        if (upd) begin
            m_flag = ex;
            if (ex != 5'd0) begin
                m_cause = m_cause | ex;
                m_trap = ((m_cause & m_en) != 5'd0);
            end
        end
        if (od && ic && !un) m_cond = ct;
        @(negedge clk);
        wr_en = 1'b0; op_done = 1'b0;
        check_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; op_done = 1'b0; op_exc = '0;
        op_is_cmp = 1'b0; cmp_unord = 1'b0; cmp_true = 1'b0;
        m_rm = '0; m_flag = '0; m_en = '0; m_cause = '0; m_ftz = 1'b0; m_cond = 1'b0; m_trap = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all();                       // R1 reset state
        rst_n = 1'b1;
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);   // R2 reserved bits masked, R4 ftz on
        chk("R2 reserved bits", rd_data, 32'h0003_FFFF);
        step(1, 32'h0000_0001, 0, 0, 0, 0, 0);   // R3 toward-zero code
        step(1, 32'h0000_0002, 0, 0, 0, 0, 0);   // R3 other code rounds nearest
        step(0, 0, 1, 5'h00, 0, 0, 0);           // R5 zero exceptions clear flags
        step(1, 32'h0000_0100, 0, 0, 0, 0, 0);   // enable underflow only
        step(0, 0, 1, 5'h02, 0, 0, 0);           // R7 trap on enabled cause
        step(0, 0, 0, 5'h00, 0, 0, 0);           // R7 pulse ends
        step(0, 0, 1, 5'h01, 0, 0, 0);           // R7 old cause still enabled -> trap
        step(0, 0, 1, 5'h00, 0, 0, 0);           // R6 cause kept, R5 flags cleared, no trap
        step(0, 0, 1, 5'h1F, 1, 0, 1);           // R8 ordered compare ignores exceptions
        step(0, 0, 1, 5'h10, 1, 1, 0);           // R9 unordered compare updates status
        step(1, 32'h0000_4201, 1, 5'h04, 0, 0, 0); // R10 write with strobe
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] wd;
            wd = $urandom;
            step(($urandom % 4) == 0, wd, ($urandom % 2) == 0,
                 (($urandom % 3) == 0) ? 5'd0 : 5'($urandom),
                 ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule